// File: doc/BRIEF.md
# Key-Unlocked Configuration Index Port

This block is the configuration front end of a multi-function peripheral. It has two byte-wide host ports: the index port selects a register and the data port reads or writes it. After reset the front end is locked. A fixed entry key, written twice in a row to the index port, unlocks it. An exit key written to the index port locks it again. While it is unlocked, every index-port write other than the exit key is stored as the current index. A data-port access then reaches the register at that index.

Indices below 0x30 hold global registers: the logical-device number, the device identification bytes, the manufacturer identification bytes and three pin-mux select bytes. Indices at 0x30 and above are banked by the logical-device number. For every logical device the block keeps an enable bit and a 16-bit base address. Any other banked index is passed to a downstream register file through a strobe and a device/index bus, and that file's read data is returned on the data port.

Top module: `cfg_index_port`

## Requirements
- R1: The port unlocks only after the index port receives the byte 0x87 on two consecutive index writes. The second of those writes does not change the stored index.
- R2: While locked, any index write other than 0x87 cancels a half-entered key, so two fresh 0x87 writes are needed again.
- R3: While unlocked, writing 0xAA to the index port locks the port. That write does not change the stored index.
- R4: While locked, data-port writes change nothing, and both ports read 0xFF. After reset the port is locked.
- R5: While unlocked, a read of the index port returns the last index stored (0x00 after reset). The stored index is kept across lock and unlock.
- R6: Index 0x07 is the read/write logical-device number. It selects the bank that answers at indices 0x30 and above.
- R7: Indices 0x20/0x21 read the device ID high and low bytes (default 0x0901). Index 0x22 reads the revision (default 0x10). Indices 0x23/0x24 read 0x19/0x34. Writes to these indices are ignored.
- R8: In the selected device, bit 0 of index 0x30 is the enable and reads back with bits 7:1 as zero. Index 0x60 holds the base address high byte and 0x61 the low byte. These registers drive dev_en and dev_base, where device d uses bits d*16+15 down to d*16.
- R9: Indices 0x29, 0x2A and 0x2B are read/write bytes that drive mux_sel bits 7:0, 15:8 and 23:16.
- R10: Any other banked index with a valid device number (below NUM_DEV) is forwarded. A data write raises bank_we for that cycle, and a data read returns bank_rdata. With an invalid device number nothing is forwarded and banked reads return 0xFF.
- R11: Unassigned global indices (below 0x30) read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe |
| port_sel | input | 1 | 0 selects the index port, 1 the data port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte of the selected port (combinational) |
| mux_sel | output | 24 | Pin-mux select bytes |
| dev_en | output | NUM_DEV | Enable bit per logical device |
| dev_base | output | NUM_DEV*16 | Base address per logical device |
| bank_we | output | 1 | Forwarded write strobe |
| bank_re | output | 1 | Forwarded read strobe |
| bank_dev | output | LDN_W | Device number of the forwarded access |
| bank_idx | output | 8 | Index of the forwarded access |
| bank_wdata | output | 8 | Forwarded write byte |
| bank_rdata | input | 8 | Read byte from the downstream register file |

## Verification
The assertions assume a write strobe lasts one clock and is never raised together with a read strobe. They also assume port_sel and wdata are steady while a strobe is high, and that bank_rdata depends only on bank_dev and bank_idx in the same cycle. The bench drives every input at the falling edge and holds each strobe for exactly one cycle. Its model of the downstream file is a pure function of device and index, so all assumptions hold across the key sequences, the banked accesses and the reset in mid-session.

// File: rtl/cfg_port_pkg.sv
// Package: shared constants of the configuration index port.
// Assumes byte-wide indices; the index values below are decoded by software.
package cfg_port_pkg;
    localparam logic [7:0] KEY_ENTER   = 8'h87;
    localparam logic [7:0] KEY_LEAVE   = 8'hAA;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_DEVID_H = 8'h20;
    localparam logic [7:0] IDX_DEVID_L = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_MFR_H   = 8'h23;
    localparam logic [7:0] IDX_MFR_L   = 8'h24;
    localparam logic [7:0] IDX_MUX0    = 8'h29;
    localparam logic [7:0] IDX_BANK    = 8'h30;
    localparam logic [7:0] IDX_ENABLE  = 8'h30;
    localparam logic [7:0] IDX_BASE_H  = 8'h60;
    localparam logic [7:0] IDX_BASE_L  = 8'h61;
    localparam logic [15:0] MFR_ID     = 16'h1934;
    localparam logic [7:0] LOCKED_READ = 8'hFF;
endpackage

// File: rtl/cfg_key_seq.sv
// Module: entry/exit key sequencer.
// Tracks a half-entered entry key while locked and holds the unlocked flag.
// Assumes idx_wr is a one-cycle strobe for each index-port write.
module cfg_key_seq
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    logic key_seen;

    // Advance the key state on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            key_seen <= 1'b0;
        end else if (idx_wr) begin
            if (unlocked) begin
                key_seen <= 1'b0;
                if (wdata == KEY_LEAVE) unlocked <= 1'b0;
            end else if (wdata == KEY_ENTER) begin
                if (key_seen) begin
                    unlocked <= 1'b1;
                    key_seen <= 1'b0;
                end else begin
                    key_seen <= 1'b1;
                end
            end else begin
                key_seen <= 1'b0;
            end
        end
    end

    AST_TWO_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_ENTER && key_seen)); // R1
    AST_BROKEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && idx_wr && wdata != KEY_ENTER) |=> !unlocked && !key_seen); // R2
    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && idx_wr && wdata == KEY_LEAVE) |=> !unlocked); // R3
endmodule

// File: rtl/cfg_global_regs.sv
// Module: global register set below the banked space.
// Holds the logical-device number and the pin-mux bytes, and returns the
// identification constants. Assumes wr is already qualified by the unlock.
module cfg_global_regs
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h0901,
    parameter logic [7:0]  DEV_REV = 8'h10,
    parameter int          NUM_MUX = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [7:0]           index,
    input  logic [7:0]           wdata,
    output logic [7:0]           ldn,
    output logic [NUM_MUX*8-1:0] mux_sel,
    output logic [7:0]           rd_val
);
    // Store the logical-device number.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ldn <= 8'h00;
        else if (wr && index == IDX_LDN)  ldn <= wdata;
    end

    for (genvar k = 0; k < NUM_MUX; k++) begin : g_mux
        // Store one pin-mux select byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mux_sel[k*8 +: 8] <= 8'h00;
            else if (wr && index == IDX_MUX0 + 8'(k))
                mux_sel[k*8 +: 8] <= wdata;
        end
    end

    // Read decode of the global indices; unassigned ones read zero.
    always_comb begin
        case (index)
            IDX_LDN:     rd_val = ldn;
            IDX_DEVID_H: rd_val = DEV_ID[15:8];
            IDX_DEVID_L: rd_val = DEV_ID[7:0];
            IDX_REV:     rd_val = DEV_REV;
            IDX_MFR_H:   rd_val = MFR_ID[15:8];
            IDX_MFR_L:   rd_val = MFR_ID[7:0];
            default:     rd_val = 8'h00;
        endcase
        for (int k = 0; k < NUM_MUX; k++)
            if (index == IDX_MUX0 + 8'(k)) rd_val = mux_sel[k*8 +: 8];
    end

    AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mux_sel)); // R9
    AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ldn)); // R6
endmodule

// File: rtl/cfg_ldev_bank.sv
// Module: per-logical-device enable and base-address registers.
// One register set is generated per device; only the selected device's
// set is written or read. Assumes wr is already qualified by the unlock.
module cfg_ldev_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [7:0]            index,
    input  logic [7:0]            wdata,
    input  logic [7:0]            ldn,
    output logic [NUM_DEV-1:0]    dev_en,
    output logic [NUM_DEV*16-1:0] dev_base,
    output logic                  ldn_ok,
    output logic                  local_hit,
    output logic [7:0]            local_val
);
    assign ldn_ok    = (ldn < 8'(NUM_DEV));
    assign local_hit = (index == IDX_ENABLE) || (index == IDX_BASE_H) ||
                       (index == IDX_BASE_L);

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic sel;
        assign sel = wr && (ldn == 8'(d));
        // Hold this device's enable bit and base address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dev_en[d]            <= 1'b0;
                dev_base[d*16 +: 16] <= 16'h0000;
            end else if (sel) begin
                if (index == IDX_ENABLE) dev_en[d]               <= wdata[0];
                if (index == IDX_BASE_H) dev_base[d*16 + 8 +: 8] <= wdata;
                if (index == IDX_BASE_L) dev_base[d*16 +: 8]     <= wdata;
            end
        end
    end

    // Read the selected device's local register.
    always_comb begin
        local_val = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (ldn == 8'(d)) begin
                if (index == IDX_ENABLE) local_val = {7'b0, dev_en[d]};
                if (index == IDX_BASE_H) local_val = dev_base[d*16 + 8 +: 8];
                if (index == IDX_BASE_L) local_val = dev_base[d*16 +: 8];
            end
        end
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && index == IDX_ENABLE) |=> $stable(dev_en)); // R8
    AST_BAD_LDN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !ldn_ok |=> $stable(dev_en) && $stable(dev_base)); // R10
endmodule

// File: rtl/cfg_index_port.sv
// Module: top of the key-unlocked configuration index port.
// Holds the index latch, steers data accesses to the global registers, to
// the per-device registers or to the downstream file, and forces 0xFF reads
// while locked. Assumes strobes last one cycle and never overlap.
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int          NUM_DEV = 8,
    parameter int          NUM_MUX = 3,
    parameter logic [15:0] DEV_ID  = 16'h0901,
    parameter logic [7:0]  DEV_REV = 8'h10,
    localparam int         LDN_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  port_sel,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NUM_MUX*8-1:0]  mux_sel,
    output logic [NUM_DEV-1:0]    dev_en,
    output logic [NUM_DEV*16-1:0] dev_base,
    output logic                  bank_we,
    output logic                  bank_re,
    output logic [LDN_W-1:0]      bank_dev,
    output logic [7:0]            bank_idx,
    output logic [7:0]            bank_wdata,
    input  logic [7:0]            bank_rdata
);
    logic       unlocked;
    logic       idx_wr, dat_wr, dat_rd;
    logic [7:0] index_q;
    logic [7:0] ldn;
    logic [7:0] g_val, l_val;
    logic       ldn_ok, local_hit, banked, fwd_hit;

    assign idx_wr = wr_en && !port_sel;
    assign dat_wr = wr_en && port_sel && unlocked;
    assign dat_rd = rd_en && port_sel && unlocked;

    cfg_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (wdata),
        .unlocked (unlocked)
    );

    // Latch the register index on unlocked index writes other than the exit key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 8'h00;
        else if (idx_wr && unlocked && wdata != KEY_LEAVE)
            index_q <= wdata;
    end

    assign banked  = (index_q >= IDX_BANK);
    assign fwd_hit = banked && !local_hit && ldn_ok;

    cfg_global_regs #(
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV),
        .NUM_MUX (NUM_MUX)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (dat_wr && !banked),
        .index   (index_q),
        .wdata   (wdata),
        .ldn     (ldn),
        .mux_sel (mux_sel),
        .rd_val  (g_val)
    );

    cfg_ldev_bank #(
        .NUM_DEV (NUM_DEV)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (dat_wr && banked && ldn_ok),
        .index     (index_q),
        .wdata     (wdata),
        .ldn       (ldn),
        .dev_en    (dev_en),
        .dev_base  (dev_base),
        .ldn_ok    (ldn_ok),
        .local_hit (local_hit),
        .local_val (l_val)
    );

    // Forward banked accesses that no local register claims.
    assign bank_we    = dat_wr && fwd_hit;
    assign bank_re    = dat_rd && fwd_hit;
    assign bank_dev   = ldn[LDN_W-1:0];
    assign bank_idx   = index_q;
    assign bank_wdata = wdata;

    // Select the byte returned on the addressed port.
    always_comb begin
        if (!unlocked)      rdata = LOCKED_READ;
        else if (!port_sel) rdata = index_q;
        else if (!banked)   rdata = g_val;
        else if (!ldn_ok)   rdata = LOCKED_READ;
        else if (local_hit) rdata = l_val;
        else                rdata = bank_rdata;
    end

    AST_LOCKED_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !bank_we && !bank_re); // R4
    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> rdata == 8'hFF); // R4
    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(index_q)); // R5
    AST_BAD_LDN_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !ldn_ok |-> !bank_we && !bank_re); // R10
    AST_FWD_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_we && bank_re)); // R10
endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;
    localparam int NUM_DEV = 8;
    localparam int LDN_W   = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
    logic [7:0]            wdata = 8'h00;
    logic [7:0]            rdata;
    logic [23:0]           mux_sel;
    logic [NUM_DEV-1:0]    dev_en;
    logic [NUM_DEV*16-1:0] dev_base;
    logic                  bank_we, bank_re;
    logic [LDN_W-1:0]      bank_dev;
    logic [7:0]            bank_idx, bank_wdata, bank_rdata;

    int tests = 0, fails = 0;
    int fwd_cnt = 0;
    logic [LDN_W-1:0] cap_dev;
    logic [7:0]       cap_idx, cap_dat;

    always #5 clk = ~clk;

    // Downstream file model: pure function of device and index.
    assign bank_rdata = bank_idx ^ {5'b0, bank_dev};

    cfg_index_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
        .mux_sel(mux_sel), .dev_en(dev_en), .dev_base(dev_base),
        .bank_we(bank_we), .bank_re(bank_re), .bank_dev(bank_dev),
        .bank_idx(bank_idx), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // Capture forwarded writes.
    always @(posedge clk) begin
        if (bank_we) begin
            fwd_cnt <= fwd_cnt + 1;
            cap_dev <= bank_dev;
            cap_idx <= bank_idx;
            cap_dat <= bank_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic [7:0] d);
        @(negedge clk);
        port_sel = p; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic p, output logic [7:0] d);
        @(negedge clk);
        port_sel = p; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // {req[3:0], op[1:0], data[7:0], expected[7:0]}; op 0=wr idx 1=wr data 2=rd idx 3=rd data
    localparam int NV = 65;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {4'd4, 2'd3, 8'h00, 8'hFF},  // R4 locked data read
        {4'd4, 2'd2, 8'h00, 8'hFF},  // R4 locked index read
        {4'd2, 2'd0, 8'h87, 8'h00},
        {4'd2, 2'd0, 8'h55, 8'h00},  // R2 breaks the key
        {4'd2, 2'd0, 8'h87, 8'h00},
        {4'd2, 2'd3, 8'h00, 8'hFF},  // R2 still locked
        {4'd1, 2'd0, 8'h87, 8'h00},  // R1 second consecutive key
        {4'd1, 2'd2, 8'h00, 8'h00},  // R1 unlocked, index unchanged
        {4'd7, 2'd0, 8'h20, 8'h00},
        {4'd7, 2'd3, 8'h00, 8'h09},  // R7 device ID high
        {4'd7, 2'd0, 8'h21, 8'h00},
        {4'd7, 2'd3, 8'h00, 8'h01},  // R7 device ID low
        {4'd7, 2'd0, 8'h22, 8'h00},
        {4'd7, 2'd3, 8'h00, 8'h10},  // R7 revision
        {4'd7, 2'd0, 8'h23, 8'h00},
        {4'd7, 2'd3, 8'h00, 8'h19},  // R7 manufacturer high
        {4'd7, 2'd0, 8'h24, 8'h00},
        {4'd7, 2'd1, 8'h00, 8'h00},
        {4'd7, 2'd3, 8'h00, 8'h34},  // R7 read-only
        {4'd9, 2'd0, 8'h29, 8'h00},
        {4'd9, 2'd1, 8'hA5, 8'h00},
        {4'd9, 2'd3, 8'h00, 8'hA5},  // R9 mux byte 0
        {4'd5, 2'd2, 8'h00, 8'h29},  // R5 index readback
        {4'd9, 2'd0, 8'h2B, 8'h00},
        {4'd9, 2'd1, 8'h3C, 8'h00},
        {4'd9, 2'd3, 8'h00, 8'h3C},  // R9 mux byte 2
        {4'd6, 2'd0, 8'h07, 8'h00},
        {4'd6, 2'd1, 8'h03, 8'h00},
        {4'd6, 2'd3, 8'h00, 8'h03},  // R6 device number
        {4'd8, 2'd0, 8'h30, 8'h00},
        {4'd8, 2'd1, 8'hFF, 8'h00},
        {4'd8, 2'd3, 8'h00, 8'h01},  // R8 enable bit only
        {4'd8, 2'd0, 8'h60, 8'h00},
        {4'd8, 2'd1, 8'h12, 8'h00},
        {4'd8, 2'd0, 8'h61, 8'h00},
        {4'd8, 2'd1, 8'h34, 8'h00},
        {4'd8, 2'd3, 8'h00, 8'h34},  // R8 base low
        {4'd8, 2'd0, 8'h60, 8'h00},
        {4'd8, 2'd3, 8'h00, 8'h12},  // R8 base high
        {4'd6, 2'd0, 8'h07, 8'h00},
        {4'd6, 2'd1, 8'h01, 8'h00},
        {4'd6, 2'd0, 8'h30, 8'h00},
        {4'd6, 2'd3, 8'h00, 8'h00},  // R6 other bank
        {4'd11, 2'd0, 8'h10, 8'h00},
        {4'd11, 2'd1, 8'h77, 8'h00},
        {4'd11, 2'd3, 8'h00, 8'h00}, // R11 unassigned global
        {4'd3, 2'd0, 8'h29, 8'h00},
        {4'd3, 2'd0, 8'hAA, 8'h00},  // R3 exit key
        {4'd3, 2'd3, 8'h00, 8'hFF},  // R3 locked
        {4'd4, 2'd1, 8'h5A, 8'h00},  // R4 ignored write
        {4'd1, 2'd0, 8'h87, 8'h00},
        {4'd1, 2'd0, 8'h87, 8'h00},
        {4'd5, 2'd2, 8'h00, 8'h29},  // R5 index kept across lock
        {4'd4, 2'd3, 8'h00, 8'hA5},  // R4 locked write had no effect
        {4'd6, 2'd0, 8'h07, 8'h00},
        {4'd6, 2'd1, 8'h03, 8'h00},
        {4'd6, 2'd0, 8'h30, 8'h00},
        {4'd6, 2'd3, 8'h00, 8'h01},  // R6 bank 3 kept its enable
        {4'd3, 2'd0, 8'hAA, 8'h00},
        {4'd2, 2'd0, 8'h87, 8'h00},
        {4'd2, 2'd0, 8'hAA, 8'h00},  // R2 non-key while locked
        {4'd2, 2'd0, 8'h87, 8'h00},
        {4'd2, 2'd3, 8'h00, 8'hFF},  // R2 one key only
        {4'd1, 2'd0, 8'h87, 8'h00},
        {4'd1, 2'd2, 8'h00, 8'h30}   // R1 unlocked again
    };

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R4 reset state
        check("R4 reset rdata", 32'(rdata), 32'hFF);
        check("R8 reset dev_en", 32'(dev_en), 32'h0);
        check("R9 reset mux_sel", 32'(mux_sel), 32'h0);
        check("R10 reset bank_we", 32'(bank_we), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq; logic [1:0] op; logic [7:0] d, e;
            {rq, op, d, e} = VEC[i];
            case (op)
                2'd0: wr(1'b0, d);
                2'd1: wr(1'b1, d);
                2'd2: begin rd(1'b0, r); check($sformatf("R%0d vec %0d", rq, i), 32'(r), 32'(e)); end
                default: begin rd(1'b1, r); check($sformatf("R%0d vec %0d", rq, i), 32'(r), 32'(e)); end
            endcase
        end

        // R9 / R8 outputs after the table
        check("R9 mux_sel", 32'(mux_sel), 32'h3C00A5);
        check("R8 dev_en", 32'(dev_en), 32'h08);
        check("R8 dev_base dev3", 32'(dev_base[3*16 +: 16]), 32'h1234);

        // R10 forwarded write and read
        wr(1'b0, 8'h07); wr(1'b1, 8'h02);
        wr(1'b0, 8'h45); wr(1'b1, 8'h6C);
        check("R10 fwd count", 32'(fwd_cnt), 32'd1);
        check("R10 fwd dev", 32'(cap_dev), 32'd2);
        check("R10 fwd idx", 32'(cap_idx), 32'h45);
        check("R10 fwd data", 32'(cap_dat), 32'h6C);
        rd(1'b1, r);
        check("R10 fwd read", 32'(r), 32'h47);

        // R10 invalid device number
        wr(1'b0, 8'h07); wr(1'b1, 8'h09);
        wr(1'b0, 8'h30);
        rd(1'b1, r);
        check("R10 bad ldn read", 32'(r), 32'hFF);
        wr(1'b0, 8'h45); wr(1'b1, 8'h11);
        check("R10 bad ldn no fwd", 32'(fwd_cnt), 32'd1);
        check("R10 bad ldn dev_en", 32'(dev_en), 32'h08);

        // R4 reset in mid-session
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1'b1, r);
        check("R4 locked after reset", 32'(r), 32'hFF);
        check("R8 dev_en cleared", 32'(dev_en), 32'h0);
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        rd(1'b0, r);
        check("R5 index cleared by reset", 32'(r), 32'h00);

        finish_run();
    end
endmodule